// File: doc/BRIEF.md
# Command Block List Manager

This block keeps a small on-chip array of command control blocks and threads them into two singly linked lists: a list of free blocks and a list of blocks whose transactions are parked while their target is off the bus. Every entry carries an 8-bit next pointer, an addressing key (target, channel and LUN packed into one field), an 8-bit tag and a tag-enable bit. Each list has a head register. The pointer value 0xFF is the null marker: it ends a list and marks an empty head.

A controller drives one command at a time through a start/busy/done handshake. The commands write an entry's fields, read an entry back, push onto either list, pop the free list, search the parked list by key or by tag, unlink a found entry through its predecessor, allocate with fallback, and look up the tag of an untagged transaction. A search reports both the matching index and its predecessor, so the caller can unlink the entry with one follow-up command. Allocation uses the free list first. If that list is empty, it evicts the head of the parked list and raises a write-back flag so the caller can copy that block out to host memory before reuse.

Top module: `cbl_mgr`

## Requirements
- R1: After reset both head outputs read 0xFF, and busy and done are low.
- R2: A command is accepted when cmd_start is high while busy is low. A start seen while busy is high is ignored. Commands that need no entry read (WRITE, PUSH_FREE, PUSH_DISC, unknown) raise done for one cycle, one cycle after acceptance. Heads change only as a result of an accepted command.
- R3: WRITE (op 0) stores cmd_key, cmd_aux as tag and cmd_ten in entry cmd_idx and leaves its next pointer unchanged. READ (op 1) returns the entry's next pointer on rsp_idx and its tag on rsp_data.
- R4: PUSH_FREE (op 2) sets the entry's next to the old free head and its tag to 0xFF, then makes the entry the free head.
- R5: PUSH_DISC (op 3) sets the entry's next to the old parked-list head and makes the entry that head.
- R6: POP_FREE (op 4) returns the free head and advances the head to that entry's next. On an empty list it returns 0xFF.
- R7: FIND (op 6) walks from cmd_idx. When cmd_aux is 0xFF it compares the key field with cmd_key; otherwise it compares the tag field with cmd_aux. On a hit it returns the index on rsp_idx and the previously visited index on rsp_prev (0xFF for the start entry). On a miss, or when the start is 0xFF, it returns 0xFF on both.
- R8: A walk reads one entry per clock. A search that visits n entries raises done n+1 cycles after acceptance.
- R9: UNLINK (op 7) removes entry cmd_idx using predecessor cmd_aux. A predecessor of 0xFF moves the parked-list head to the entry's next. Any other predecessor gets the entry's next written into its own next field.
- R10: ALLOC (op 5) pops the free head with rsp_wb low when that list is non-empty. Otherwise it takes the parked-list head, advances that head and sets rsp_wb high. With both lists empty it returns 0xFF with rsp_wb low.
- R11: LOOKUP (op 8) searches the parked list from its head by cmd_key. It returns the matching entry's tag when that entry's tag-enable bit is clear, and 0xFF when the bit is set or no entry matches.
- R12: A walk stops after visiting NUM_ENTRIES entries and reports a miss, so a list corrupted into a cycle cannot hang the block.
- R13: An op code above 8 completes one cycle after acceptance with 0xFF results and changes no head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start request for a command |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 8 | Entry index, or start index for FIND |
| cmd_aux | input | 8 | Tag for WRITE/FIND, predecessor for UNLINK |
| cmd_key | input | KEY_W | Key for WRITE, FIND and LOOKUP |
| cmd_ten | input | 1 | Tag-enable bit for WRITE |
| busy | output | 1 | A command is executing |
| done | output | 1 | One-cycle completion pulse |
| rsp_idx | output | 8 | Result index, next pointer or tag |
| rsp_prev | output | 8 | Predecessor of a search hit |
| rsp_data | output | 8 | Tag of the entry read or matched |
| rsp_wb | output | 1 | Allocated entry must be written back to the host |
| free_head | output | 8 | Free-list head |
| disc_head | output | 8 | Parked-list head |

## Verification
The bench builds the block with its default of 16 entries and 8-bit keys. This lets it thread every entry onto the parked list and search for each one by key, by tag and through the untagged lookup, so every list position, from the head through the last entry, is exercised along with the exact latency each position implies. The small array also lets both lists be drained to empty, so every fallback branch of allocation is reached. It also lets a two-entry cycle be built that drives the walk into its visit bound.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int PTR_W = 8;
  localparam logic [PTR_W-1:0] NULL_PTR = 8'hFF;

  typedef enum logic [3:0] {
    OP_WRITE     = 4'd0,
    OP_READ      = 4'd1,
    OP_PUSH_FREE = 4'd2,
    OP_PUSH_DISC = 4'd3,
    OP_POP_FREE  = 4'd4,
    OP_ALLOC     = 4'd5,
    OP_FIND      = 4'd6,
    OP_UNLINK    = 4'd7,
    OP_LOOKUP    = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_POP,
    S_WALK,
    S_UNLINK
  } state_e;
endpackage

// File: rtl/cbl_entry_ram.sv
module cbl_entry_ram #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 8,
  parameter int PTR_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    rd_addr,
  input  logic [AW-1:0]    wr_addr,
  input  logic             we_next,
  input  logic             we_key,
  input  logic             we_tag,
  input  logic             we_ten,
  input  logic [PTR_W-1:0] wr_next,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [PTR_W-1:0] wr_tag,
  input  logic             wr_ten,
  output logic [PTR_W-1:0] q_next,
  output logic [KEY_W-1:0] q_key,
  output logic [PTR_W-1:0] q_tag,
  output logic             q_ten
);
  // One array per field so each has its own write enable; synchronous read.
  logic [PTR_W-1:0] mem_next [DEPTH];
  logic [KEY_W-1:0] mem_key  [DEPTH];
  logic [PTR_W-1:0] mem_tag  [DEPTH];
  logic             mem_ten  [DEPTH];

  always_ff @(posedge clk) begin
    if (we_next) mem_next[wr_addr] <= wr_next;
    q_next <= mem_next[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (we_key) mem_key[wr_addr] <= wr_key;
    q_key <= mem_key[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (we_tag) mem_tag[wr_addr] <= wr_tag;
    q_tag <= mem_tag[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (we_ten) mem_ten[wr_addr] <= wr_ten;
    q_ten <= mem_ten[rd_addr];
  end
endmodule

// File: rtl/cbl_match.sv
module cbl_match #(
  parameter int KEY_W = 8,
  parameter int PTR_W = 8
) (
  input  logic             by_tag,
  input  logic [KEY_W-1:0] ent_key,
  input  logic [PTR_W-1:0] ent_tag,
  input  logic [KEY_W-1:0] want_key,
  input  logic [PTR_W-1:0] want_tag,
  output logic             hit
);
  always_comb begin
    if (by_tag) hit = (ent_tag == want_tag);
    else        hit = (ent_key == want_key);
  end
endmodule

// File: rtl/cbl_mgr.sv
module cbl_mgr
  import cbl_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [3:0]       cmd_op,
  input  logic [7:0]       cmd_idx,
  input  logic [7:0]       cmd_aux,
  input  logic [KEY_W-1:0] cmd_key,
  input  logic             cmd_ten,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rsp_idx,
  output logic [7:0]       rsp_prev,
  output logic [7:0]       rsp_data,
  output logic             rsp_wb,
  output logic [7:0]       free_head,
  output logic [7:0]       disc_head
);
  localparam int AW    = $clog2(NUM_ENTRIES);
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);
  localparam logic [CNT_W-1:0] STEP_MAX = CNT_W'(NUM_ENTRIES);

  state_e           state;
  logic [PTR_W-1:0] cur, prev_q, aux_q;
  logic [KEY_W-1:0] key_q;
  logic             src_disc, by_tag_q, lookup_q;
  logic [CNT_W-1:0] steps;

  logic [PTR_W-1:0] rd_ptr;
  logic [AW-1:0]    rd_addr, wr_addr;
  logic             we_next, we_key, we_tag, we_ten;
  logic [PTR_W-1:0] wr_next, wr_tag;
  logic [KEY_W-1:0] wr_key;
  logic             wr_ten;
  logic [PTR_W-1:0] q_next, q_tag;
  logic [KEY_W-1:0] q_key;
  logic             q_ten;
  logic             hit;
  logic             accept;

  assign busy    = (state != S_IDLE);
  assign accept  = cmd_start && (state == S_IDLE);
  assign rd_addr = rd_ptr[AW-1:0];

  cbl_entry_ram #(
    .DEPTH(NUM_ENTRIES), .KEY_W(KEY_W), .PTR_W(PTR_W)
  ) u_ram (
    .clk(clk), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .we_next(we_next), .we_key(we_key), .we_tag(we_tag), .we_ten(we_ten),
    .wr_next(wr_next), .wr_key(wr_key), .wr_tag(wr_tag), .wr_ten(wr_ten),
    .q_next(q_next), .q_key(q_key), .q_tag(q_tag), .q_ten(q_ten)
  );

  cbl_match #(.KEY_W(KEY_W), .PTR_W(PTR_W)) u_match (
    .by_tag(by_tag_q), .ent_key(q_key), .ent_tag(q_tag),
    .want_key(key_q), .want_tag(aux_q), .hit(hit)
  );

  // Read address and write port control.
  always_comb begin
    rd_ptr  = cur;
    wr_addr = cmd_idx[AW-1:0];
    we_next = 1'b0;
    we_key  = 1'b0;
    we_tag  = 1'b0;
    we_ten  = 1'b0;
    wr_next = NULL_PTR;
    wr_key  = cmd_key;
    wr_tag  = cmd_aux;
    wr_ten  = cmd_ten;
    case (state)
      S_IDLE: begin
        if (accept) begin
          case (op_e'(cmd_op))
            OP_WRITE: begin
              we_key = 1'b1;
              we_tag = 1'b1;
              we_ten = 1'b1;
            end
            OP_PUSH_FREE: begin
              we_next = 1'b1;
              wr_next = free_head;
              we_tag  = 1'b1;
              wr_tag  = NULL_PTR;
            end
            OP_PUSH_DISC: begin
              we_next = 1'b1;
              wr_next = disc_head;
            end
            OP_READ, OP_FIND, OP_UNLINK: rd_ptr = cmd_idx;
            OP_POP_FREE: rd_ptr = free_head;
            OP_ALLOC:    rd_ptr = (free_head != NULL_PTR) ? free_head : disc_head;
            OP_LOOKUP:   rd_ptr = disc_head;
            default:     rd_ptr = cur;
          endcase
        end
      end
      S_WALK: begin
        if (!hit && q_next != NULL_PTR && steps != STEP_MAX) rd_ptr = q_next;
      end
      S_UNLINK: begin
        if (aux_q != NULL_PTR) begin
          we_next = 1'b1;
          wr_addr = aux_q[AW-1:0];
          wr_next = q_next;
        end
      end
      default: rd_ptr = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      free_head <= NULL_PTR;
      disc_head <= NULL_PTR;
      done      <= 1'b0;
      rsp_idx   <= NULL_PTR;
      rsp_prev  <= NULL_PTR;
      rsp_data  <= NULL_PTR;
      rsp_wb    <= 1'b0;
      cur       <= NULL_PTR;
      prev_q    <= NULL_PTR;
      aux_q     <= NULL_PTR;
      key_q     <= '0;
      src_disc  <= 1'b0;
      by_tag_q  <= 1'b0;
      lookup_q  <= 1'b0;
      steps     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            aux_q    <= cmd_aux;
            key_q    <= cmd_key;
            rsp_idx  <= NULL_PTR;
            rsp_prev <= NULL_PTR;
            rsp_data <= NULL_PTR;
            rsp_wb   <= 1'b0;
            case (op_e'(cmd_op))
              OP_WRITE: begin
                done    <= 1'b1;
                rsp_idx <= cmd_idx;
              end
              OP_PUSH_FREE: begin
                free_head <= cmd_idx;
                done      <= 1'b1;
                rsp_idx   <= cmd_idx;
              end
              OP_PUSH_DISC: begin
                disc_head <= cmd_idx;
                done      <= 1'b1;
                rsp_idx   <= cmd_idx;
              end
              OP_READ: begin
                cur   <= cmd_idx;
                state <= S_READ;
              end
              OP_POP_FREE: begin
                if (free_head == NULL_PTR) done <= 1'b1;
                else begin
                  cur      <= free_head;
                  src_disc <= 1'b0;
                  state    <= S_POP;
                end
              end
              OP_ALLOC: begin
                if (free_head != NULL_PTR) begin
                  cur      <= free_head;
                  src_disc <= 1'b0;
                  state    <= S_POP;
                end else if (disc_head != NULL_PTR) begin
                  cur      <= disc_head;
                  src_disc <= 1'b1;
                  state    <= S_POP;
                end else done <= 1'b1;
              end
              OP_FIND: begin
                if (cmd_idx == NULL_PTR) done <= 1'b1;
                else begin
                  cur      <= cmd_idx;
                  prev_q   <= NULL_PTR;
                  by_tag_q <= (cmd_aux != NULL_PTR);
                  lookup_q <= 1'b0;
                  steps    <= CNT_W'(1);
                  state    <= S_WALK;
                end
              end
              OP_LOOKUP: begin
                if (disc_head == NULL_PTR) done <= 1'b1;
                else begin
                  cur      <= disc_head;
                  prev_q   <= NULL_PTR;
                  by_tag_q <= 1'b0;
                  lookup_q <= 1'b1;
                  steps    <= CNT_W'(1);
                  state    <= S_WALK;
                end
              end
              OP_UNLINK: begin
                cur   <= cmd_idx;
                state <= S_UNLINK;
              end
              default: done <= 1'b1;
            endcase
          end
        end
        S_READ: begin
          done     <= 1'b1;
          rsp_idx  <= q_next;
          rsp_data <= q_tag;
          state    <= S_IDLE;
        end
        S_POP: begin
          done    <= 1'b1;
          rsp_idx <= cur;
          rsp_wb  <= src_disc;
          if (src_disc) disc_head <= q_next;
          else          free_head <= q_next;
          state   <= S_IDLE;
        end
        S_WALK: begin
          if (hit) begin
            done     <= 1'b1;
            rsp_prev <= prev_q;
            rsp_data <= q_tag;
            if (lookup_q) rsp_idx <= q_ten ? NULL_PTR : q_tag;
            else          rsp_idx <= cur;
            state    <= S_IDLE;
          end else if (q_next == NULL_PTR || steps == STEP_MAX) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            prev_q <= cur;
            cur    <= q_next;
            steps  <= steps + CNT_W'(1);
          end
        end
        S_UNLINK: begin
          if (aux_q == NULL_PTR) disc_head <= q_next;
          done    <= 1'b1;
          rsp_idx <= cur;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbl_mgr_chk.sv
module cbl_mgr_chk #(
  parameter int KEY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_start,
  input logic [3:0]       cmd_op,
  input logic [7:0]       cmd_idx,
  input logic             busy,
  input logic             done,
  input logic [7:0]       rsp_idx,
  input logic             rsp_wb,
  input logic [7:0]       free_head,
  input logic [7:0]       disc_head
);
  AST_RESET_HEADS_NULL: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (free_head == 8'hFF && disc_head == 8'hFF && !busy)); // R1

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R2

  AST_IDLE_HEADS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_start) |=> ($stable(free_head) && $stable(disc_head))); // R2

  AST_PUSH_FREE_HEAD: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !busy && cmd_op == 4'd2) |=> (free_head == $past(cmd_idx) && done)); // R4

  AST_PUSH_DISC_HEAD: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !busy && cmd_op == 4'd3) |=> (disc_head == $past(cmd_idx) && done)); // R5

  AST_WB_HAS_INDEX: assert property (@(posedge clk) disable iff (rst)
    (done && rsp_wb) |-> (rsp_idx != 8'hFF)); // R10

  AST_UNKNOWN_OP_NULL: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !busy && cmd_op > 4'd8) |=> (done && rsp_idx == 8'hFF && !rsp_wb)); // R13
endmodule

bind cbl_mgr cbl_mgr_chk #(.KEY_W(KEY_W)) u_cbl_mgr_chk (
  .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
  .cmd_idx(cmd_idx), .busy(busy), .done(done), .rsp_idx(rsp_idx),
  .rsp_wb(rsp_wb), .free_head(free_head), .disc_head(disc_head)
);

// File: tb/cbl_mgr_bench.sv
module cbl_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [7:0] NUL = 8'hFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [7:0] cmd_idx = 8'd0, cmd_aux = 8'd0, cmd_key = 8'd0;
  logic cmd_ten = 1'b0;
  logic busy, done, rsp_wb;
  logic [7:0] rsp_idx, rsp_prev, rsp_data, free_head, disc_head;

  int checks = 0;
  int errors = 0;
  int lat;

  logic [7:0] m_next [N];
  logic [7:0] m_tag  [N];
  logic [7:0] m_key  [N];
  logic       m_ten  [N];
  logic [7:0] m_free = NUL;
  logic [7:0] m_disc = NUL;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbl_mgr #(.NUM_ENTRIES(N), .KEY_W(8)) u_cbl_mgr (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_aux(cmd_aux), .cmd_key(cmd_key), .cmd_ten(cmd_ten),
    .busy(busy), .done(done), .rsp_idx(rsp_idx), .rsp_prev(rsp_prev),
    .rsp_data(rsp_data), .rsp_wb(rsp_wb), .free_head(free_head),
    .disc_head(disc_head)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] idx, input logic [7:0] aux,
                     input logic [7:0] key, input logic ten);
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_aux = aux; cmd_key = key; cmd_ten = ten;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // Walk of the reference lists; visits counts entries read.
  task automatic mfind(input logic [7:0] start, input logic [7:0] aux, input logic [7:0] key,
                       output logic [7:0] idx, output logic [7:0] prv, output int visits);
    logic [7:0] c, p;
    bit m;
    idx = NUL; prv = NUL; visits = 0;
    c = start; p = NUL;
    while (c != NUL) begin
      visits++;
      m = (aux == NUL) ? (m_key[c[3:0]] == key) : (m_tag[c[3:0]] == aux);
      if (m) begin idx = c; prv = p; break; end
      if (m_next[c[3:0]] == NUL || visits == N) break;
      p = c;
      c = m_next[c[3:0]];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e_idx, e_prv, victim;
    int vis;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "free_head", free_head, NUL);
    chk("R1", "disc_head", disc_head, NUL);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);

    // R3: fill every entry
    for (int i = 0; i < N; i++) begin
      m_key[i] = 8'h40 + 8'(i);
      m_tag[i] = 8'h20 + 8'(i);
      m_ten[i] = (i % 3 == 0);
      run(4'd0, 8'(i), m_tag[i], m_key[i], m_ten[i]);
      chk("R3", "write latency", lat, 1);
      chk("R3", "write rsp_idx", rsp_idx, i);
    end

    // R5: park every entry
    for (int i = 0; i < N; i++) begin
      run(4'd3, 8'(i), 8'd0, 8'd0, 1'b0);
      m_next[i] = m_disc; m_disc = 8'(i);
      chk("R5", "disc_head after push", disc_head, i);
      chk("R2", "push latency", lat, 1);
    end
    for (int i = 0; i < N; i++) begin
      run(4'd1, 8'(i), 8'd0, 8'd0, 1'b0);
      chk("R5", "next pointer", rsp_idx, m_next[i]);
      chk("R3", "tag readback", rsp_data, m_tag[i]);
    end

    // R7/R8: search every position by key and by tag
    for (int i = 0; i < N; i++) begin
      mfind(m_disc, NUL, m_key[i], e_idx, e_prv, vis);
      run(4'd6, m_disc, NUL, m_key[i], 1'b0);
      chk("R7", "key hit idx", rsp_idx, e_idx);
      chk("R7", "key hit prev", rsp_prev, e_prv);
      chk("R8", "key search latency", lat, vis + 1);
      mfind(m_disc, m_tag[i], 8'h00, e_idx, e_prv, vis);
      run(4'd6, m_disc, m_tag[i], 8'h00, 1'b0);
      chk("R7", "tag hit idx", rsp_idx, e_idx);
      chk("R7", "tag hit prev", rsp_prev, e_prv);
      chk("R8", "tag search latency", lat, vis + 1);
    end
    run(4'd6, m_disc, NUL, 8'h00, 1'b0);
    chk("R7", "miss idx", rsp_idx, NUL);
    chk("R7", "miss prev", rsp_prev, NUL);
    chk("R8", "full miss latency", lat, N + 1);
    run(4'd6, NUL, NUL, m_key[3], 1'b0);
    chk("R7", "null start idx", rsp_idx, NUL);
    chk("R8", "null start latency", lat, 1);

    // R11: untagged lookup
    for (int i = 0; i < N; i++) begin
      run(4'd8, 8'd0, 8'd0, m_key[i], 1'b0);
      chk("R11", "lookup result", rsp_idx, m_ten[i] ? NUL : m_tag[i]);
    end
    run(4'd8, 8'd0, 8'd0, 8'h01, 1'b0);
    chk("R11", "lookup miss", rsp_idx, NUL);

    // R9: unlink from the middle, then the head
    mfind(m_disc, NUL, m_key[7], e_idx, e_prv, vis);
    run(4'd7, 8'd7, e_prv, 8'd0, 1'b0);
    m_next[e_prv[3:0]] = m_next[7];
    run(4'd1, e_prv, 8'd0, 8'd0, 1'b0);
    chk("R9", "predecessor next", rsp_idx, m_next[e_prv[3:0]]);
    run(4'd6, m_disc, NUL, m_key[7], 1'b0);
    chk("R9", "unlinked entry gone", rsp_idx, NUL);
    victim = m_disc;
    run(4'd7, victim, NUL, 8'd0, 1'b0);
    m_disc = m_next[victim[3:0]];
    chk("R9", "head unlink", disc_head, m_disc);

    // R6/R10: empty free list
    run(4'd4, 8'd0, 8'd0, 8'd0, 1'b0);
    chk("R6", "pop empty", rsp_idx, NUL);
    run(4'd5, 8'd0, 8'd0, 8'd0, 1'b0);
    chk("R10", "evict idx", rsp_idx, m_disc);
    chk("R10", "evict wb", rsp_wb, 1);
    m_disc = m_next[m_disc[3:0]];
    chk("R10", "disc advanced", disc_head, m_disc);

    // R4: free list pushes
    run(4'd2, victim, 8'd0, 8'd0, 1'b0);
    m_next[victim[3:0]] = m_free; m_free = victim; m_tag[victim[3:0]] = NUL;
    run(4'd2, 8'd7, 8'd0, 8'd0, 1'b0);
    m_next[7] = m_free; m_free = 8'd7; m_tag[7] = NUL;
    chk("R4", "free_head", free_head, 7);
    run(4'd1, 8'd7, 8'd0, 8'd0, 1'b0);
    chk("R4", "free next", rsp_idx, victim);
    chk("R4", "free tag null", rsp_data, NUL);
    run(4'd4, 8'd0, 8'd0, 8'd0, 1'b0);
    chk("R6", "pop idx", rsp_idx, 7);
    chk("R6", "pop head advanced", free_head, victim);
    run(4'd5, 8'd0, 8'd0, 8'd0, 1'b0);
    chk("R10", "alloc from free", rsp_idx, victim);
    chk("R10", "alloc from free wb", rsp_wb, 0);
    chk("R10", "free now empty", free_head, NUL);

    // R10: drain the parked list
    while (m_disc != NUL) begin
      run(4'd5, 8'd0, 8'd0, 8'd0, 1'b0);
      chk("R10", "drain idx", rsp_idx, m_disc);
      chk("R10", "drain wb", rsp_wb, 1);
      m_disc = m_next[m_disc[3:0]];
    end
    run(4'd5, 8'd0, 8'd0, 8'd0, 1'b0);
    chk("R10", "both empty idx", rsp_idx, NUL);
    chk("R10", "both empty wb", rsp_wb, 0);
    chk("R10", "disc empty", disc_head, NUL);

    // R12: cyclic list 3 -> 5 -> 3
    run(4'd3, 8'd3, 8'd0, 8'd0, 1'b0);
    run(4'd3, 8'd5, 8'd0, 8'd0, 1'b0);
    run(4'd3, 8'd3, 8'd0, 8'd0, 1'b0);
    run(4'd6, 8'd3, NUL, 8'h00, 1'b0);
    chk("R12", "cycle miss idx", rsp_idx, NUL);
    chk("R12", "cycle bound latency", lat, N + 1);

    // R2: start while busy is ignored
    @(negedge clk);
    cmd_op = 4'd6; cmd_idx = 8'd3; cmd_aux = NUL; cmd_key = 8'h00; cmd_start = 1'b1;
    @(negedge clk);
    chk("R2", "busy after accept", busy, 1);
    cmd_op = 4'd2; cmd_idx = 8'd9;
    @(negedge clk);
    cmd_start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    @(negedge clk);
    chk("R2", "ignored push left free_head", free_head, NUL);
    chk("R2", "no second done", done, 0);

    // R13: unknown op
    run(4'd12, 8'd2, 8'd0, 8'd0, 1'b0);
    chk("R13", "unknown latency", lat, 1);
    chk("R13", "unknown idx", rsp_idx, NUL);
    chk("R13", "unknown free_head", free_head, NUL);
    chk("R13", "unknown disc_head", disc_head, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule